// File: doc/BRIEF.md
# I2C Bus-Stuck Recovery Sequencer

This block frees an I2C bus whose data line is held low by a target that was cut off in the middle of a transfer. On a start strobe it looks at SDA through a synchronizer. If the line is already high it reports at once with a count of zero and touches neither line. If SDA is low, it clocks SCL through open-drain pulses of programmable half-period until the target lets go of SDA or a pulse limit is reached. It then forms a STOP condition and signals completion with the number of pulses it issued.

Both outputs are open-drain enables: a 1 pulls the line low and a 0 releases it to the pull-up. The half-period is given in clock cycles, normally half of the bus period for the wanted speed, and it is captured when a start is accepted. Ordinary bus traffic is outside this block. It is meant to sit beside a controller and run before that controller takes the bus.

Top module: `i2c_unstick_seq`

## Requirements
- R1: Out of reset, and whenever busy_o is low, scl_oe_o and sda_oe_o are 0, done_o is 0; pulses_o is 0 after reset.
- R2: When the synchronized SDA is high at the check made one cycle after an accepted start, no SCL pulse and no STOP are produced, done_o rises two clock edges after the edge that took the start, busy_o is high for exactly two cycles, and pulses_o reads 0.
- R3: Each SCL pulse releases SCL (scl_oe_o = 0) for half_cycles_i clock cycles and then drives it low (scl_oe_o = 1) for half_cycles_i clock cycles; the low half of the final pulse lasts one extra cycle, the STOP setup cycle.
- R4: At the end of every low half the block takes the SDA value seen through a two-flop synchronizer; if SDA is still low and fewer than MAX_PULSES (default 9) pulses have been issued, another pulse follows, otherwise pulsing stops. pulses_o equals the number of pulses issued.
- R5: No more than MAX_PULSES pulses are issued when SDA never releases, and pulses_o never exceeds MAX_PULSES.
- R6: The STOP is formed by asserting sda_oe_o while scl_oe_o is still 1, releasing SCL one cycle later, keeping SDA driven for half_cycles_i cycles with SCL released, releasing SDA while SCL is released, and then waiting half_cycles_i cycles.
- R7: done_o is a single-cycle strobe in the last cycle of busy_o; busy_o is high from the cycle after the accepted start until done_o inclusive, 2*N*(P+1)+3 cycles for N half-period cycles and P>0 pulses.
- R8: A start strobe while busy_o is high is ignored: the sequence, its length and its pulse count are unchanged and done_o fires once.
- R9: pulses_o holds its value while idle until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| half_cycles_i | input | HALF_W | SCL half-period in clock cycles, captured on start |
| sda_i | input | 1 | SDA line level as read at the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Recovery sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pulses_o | output | CNT_W | Number of SCL pulses issued in the last run |

## Verification
The assertions assume that start_i and half_cycles_i are driven synchronously and that sda_i may change at any time, with the block itself seeing it only through its synchronizer. The properties on STOP ordering take for granted that nothing outside resets the sequencer mid-run. The bench keeps to this by changing inputs just after a rising edge. Its model target releases SDA on a falling SCL edge, and every run that expects an early exit uses a half-period of at least three cycles, so that the release passes the synchronizer before the low half ends.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SAMPLE,
      ST_SCL_HI,
      ST_SCL_LO,
      ST_STOP_SETUP,
      ST_STOP_SCL,
      ST_STOP_SDA,
      ST_FINISH
   } unstick_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b1;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] len_i,
   output logic         expire_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= (len_i == '0) ? '0 : len_i - W'(1);
      else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
   end

   assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/unstick_pulse_cnt.sv
module unstick_pulse_cnt #(
   parameter int MAX = 9,
   parameter int W   = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         inc_i,
   output logic [W-1:0] count_o,
   output logic         at_cap_o
);
   logic [W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (clear_i) count_q <= '0;
      else if (inc_i)   count_q <= count_q + W'(1);
   end

   assign count_o  = count_q;
   assign at_cap_o = (count_q == W'(MAX - 1));
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
   import i2c_unstick_pkg::*;
#(
   parameter int  HALF_W      = 16,
   parameter int  MAX_PULSES  = 9,
   parameter int  SYNC_STAGES = 2,
   localparam int CNT_W       = $clog2(MAX_PULSES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [HALF_W-1:0] half_cycles_i,
   input  logic              sda_i,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  pulses_o
);
   generate
      if (MAX_PULSES < 1) begin : g_bad_max
         $error("MAX_PULSES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (HALF_W < 1) begin : g_bad_half
         $error("HALF_W must be at least 1");
      end
   endgenerate

   unstick_state_e    state_q, state_d;
   logic [HALF_W-1:0] half_q;
   logic              sda_s;
   logic              expire;
   logic              load_t, inc_t, clr_t, at_cap;
   logic              scl_oe_q, sda_oe_q;

   unstick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sda_i),
      .q_o   (sda_s)
   );

   unstick_timer #(.W(HALF_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_t),
      .len_i    (half_q),
      .expire_o (expire)
   );

   unstick_pulse_cnt #(.MAX(MAX_PULSES), .W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clr_t),
      .inc_i    (inc_t),
      .count_o  (pulses_o),
      .at_cap_o (at_cap)
   );

   always_comb begin
      state_d = state_q;
      load_t  = 1'b0;
      inc_t   = 1'b0;
      clr_t   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_SAMPLE;
               clr_t   = 1'b1;
            end
         end
         ST_SAMPLE: begin
            if (sda_s) begin
               state_d = ST_FINISH;
            end else begin
               state_d = ST_SCL_HI;
               load_t  = 1'b1;
            end
         end
         ST_SCL_HI: begin
            if (expire) begin
               state_d = ST_SCL_LO;
               load_t  = 1'b1;
            end
         end
         ST_SCL_LO: begin
            if (expire) begin
               inc_t = 1'b1;
               if (!sda_s && !at_cap) begin
                  state_d = ST_SCL_HI;
                  load_t  = 1'b1;
               end else begin
                  state_d = ST_STOP_SETUP;
               end
            end
         end
         ST_STOP_SETUP: begin
            state_d = ST_STOP_SCL;
            load_t  = 1'b1;
         end
         ST_STOP_SCL: begin
            if (expire) begin
               state_d = ST_STOP_SDA;
               load_t  = 1'b1;
            end
         end
         ST_STOP_SDA: begin
            if (expire) state_d = ST_FINISH;
         end
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         half_q   <= '0;
         scl_oe_q <= 1'b0;
         sda_oe_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         if (state_q == ST_IDLE && start_i) half_q <= half_cycles_i;
         scl_oe_q <= (state_d == ST_SCL_LO) || (state_d == ST_STOP_SETUP);
         sda_oe_q <= (state_d == ST_STOP_SETUP) || (state_d == ST_STOP_SCL);
      end
   end

   assign scl_oe_o = scl_oe_q;
   assign sda_oe_o = sda_oe_q;
   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = (state_q == ST_FINISH);
endmodule

// File: rtl/unstick_checker.sv
module unstick_checker #(
   parameter int MAX_PULSES = 9,
   parameter int CNT_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             scl_oe_o,
   input logic             sda_oe_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [CNT_W-1:0] pulses_o
);
   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_oe_o && !sda_oe_o && !done_o));

   p_pulse_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulses_o <= CNT_W'(MAX_PULSES));

   p_sda_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> scl_oe_o);

   p_stop_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe_o) |-> !scl_oe_o);

   p_done_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(pulses_o));
endmodule

bind i2c_unstick_seq unstick_checker #(
   .MAX_PULSES (MAX_PULSES),
   .CNT_W      (CNT_W)
) u_unstick_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .scl_oe_o (scl_oe_o),
   .sda_oe_o (sda_oe_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .pulses_o (pulses_o)
);

// File: tb/tb_i2c_unstick_seq.sv
module tb_i2c_unstick_seq;
   localparam int HALF_W = 16;
   localparam int MAXP   = 9;
   localparam int CNT_W  = $clog2(MAXP + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [HALF_W-1:0] half_cycles_i = '0;
   logic              scl_oe_o, sda_oe_o, busy_o, done_o;
   logic [CNT_W-1:0]  pulses_o;

   // bus model: target holds SDA low until a number of SCL falls
   logic hold = 1'b0;
   int   release_after = 0;
   int   falls = 0;
   wire  sda_line = !(sda_oe_o || hold);

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   i2c_unstick_seq #(.HALF_W(HALF_W), .MAX_PULSES(MAXP)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .half_cycles_i (half_cycles_i),
      .sda_i         (sda_line),
      .scl_oe_o      (scl_oe_o),
      .sda_oe_o      (sda_oe_o),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .pulses_o      (pulses_o)
   );

   // run recorder, sampled on the falling clock edge
   int lo_run [0:15];
   int hi_run [0:15];
   int nlo, nhi, run, srun, sda_run_len, tail, tail_at_done;
   int sda_rises, setup_bad, release_bad, done_cnt, busy_cnt, scl_falls;
   bit prev_scl, prev_sda, after_fall;

   task automatic clear_rec();
      nlo = 0; nhi = 0; run = 0; srun = 0; sda_run_len = 0;
      tail = 0; tail_at_done = 0; sda_rises = 0; setup_bad = 0;
      release_bad = 0; done_cnt = 0; busy_cnt = 0; scl_falls = 0;
      prev_scl = 1'b0; prev_sda = 1'b0; after_fall = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_oe_o == prev_scl) run++;
         else begin
            if (prev_scl && nlo < 16) begin lo_run[nlo] = run; nlo++; end
            else if (!prev_scl && nlo > 0 && nhi < 16) begin hi_run[nhi] = run; nhi++; end
            run = 1;
         end
         if (scl_oe_o && !prev_scl) begin
            scl_falls++;
            if (hold && release_after > 0) begin
               falls++;
               if (falls >= release_after) hold = 1'b0;
            end
         end
         if (after_fall) tail++;
         if (sda_oe_o && !prev_sda) begin
            sda_rises++;
            if (!scl_oe_o) setup_bad++;
            srun = 0;
         end
         if (sda_oe_o) srun++;
         if (!sda_oe_o && prev_sda) begin
            sda_run_len = srun;
            if (scl_oe_o) release_bad++;
            after_fall = 1'b1;
            tail = 1;
         end
         if (busy_o) busy_cnt++;
         if (done_o) begin
            done_cnt++;
            tail_at_done = tail;
            after_fall = 1'b0;
         end
         prev_scl = scl_oe_o;
         prev_sda = sda_oe_o;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // R1: reset state
   task automatic t_reset();
      @(negedge clk);
      chk(!scl_oe_o && !sda_oe_o, "R1 line enables idle", {scl_oe_o, sda_oe_o}, 0);
      chk(!busy_o && !done_o, "R1 busy/done idle", {busy_o, done_o}, 0);
      chk(pulses_o == 0, "R1 pulse count reset", pulses_o, 0);
   endtask

   // R2: SDA already free, exact strobe timing
   task automatic t_sda_free(input int n);
      @(posedge clk); #1;
      clear_rec();
      half_cycles_i = HALF_W'(n);
      hold = 1'b0; release_after = 0; falls = 0;
      repeat (4) @(posedge clk);
      #1 start_i = 1'b1;
      @(posedge clk); #1 start_i = 1'b0;
      @(negedge clk);
      chk(busy_o && !done_o, "R2 busy after start, no done yet", {busy_o, done_o}, 2);
      @(negedge clk);
      chk(done_o == 1'b1, "R2 done two edges after start", done_o, 1);
      chk(pulses_o == 0, "R2 zero pulses reported", pulses_o, 0);
      @(negedge clk);
      chk(!busy_o, "R2 busy cleared after done", busy_o, 0);
      chk(scl_falls == 0 && sda_rises == 0, "R2 no SCL pulse and no STOP",
          scl_falls + sda_rises, 0);
      chk(busy_cnt == 2, "R2 busy length", busy_cnt, 2);
   endtask

   // one recovery run; rel = 0 means the target never lets go
   task automatic t_recover(input int n, input int rel, input int exp_p,
                            input bit inject, input string tag);
      int waited;
      @(posedge clk); #1;
      clear_rec();
      half_cycles_i = HALF_W'(n);
      hold = 1'b1; release_after = rel; falls = 0;
      repeat (4) @(posedge clk);
      #1 start_i = 1'b1;
      @(posedge clk); #1 start_i = 1'b0;
      if (inject) begin
         repeat (3 * n) @(posedge clk);
         #1 start_i = 1'b1;
         half_cycles_i = HALF_W'(n + 7);
         @(posedge clk); #1 start_i = 1'b0;
      end
      waited = 0;
      while (!done_o && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      @(posedge clk); #1;
      chk(done_o || waited < 5000, {tag, " R7 done reached"}, waited, 0);
      chk(pulses_o == CNT_W'(exp_p), {tag, " R4 R5 pulse count"}, pulses_o, exp_p);
      chk(nlo == exp_p, {tag, " R4 SCL low pulses seen"}, nlo, exp_p);
      for (int i = 0; i < nlo; i++) begin
         if (i < nlo - 1)
            chk(lo_run[i] == n, {tag, " R3 SCL low half length"}, lo_run[i], n);
         else
            chk(lo_run[i] == n + 1, {tag, " R3 R6 last low half with setup"}, lo_run[i], n + 1);
      end
      for (int i = 0; i < nhi; i++)
         chk(hi_run[i] == n, {tag, " R3 SCL high half length"}, hi_run[i], n);
      chk(nhi == exp_p - 1, {tag, " R3 high halves between pulses"}, nhi, exp_p - 1);
      chk(sda_rises == 1 && setup_bad == 0, {tag, " R6 SDA pulled while SCL low"},
          setup_bad, 0);
      chk(release_bad == 0, {tag, " R6 SDA released with SCL high"}, release_bad, 0);
      chk(sda_run_len == n + 1, {tag, " R6 SDA low span"}, sda_run_len, n + 1);
      chk(tail_at_done == n + 1, {tag, " R6 wait after STOP"}, tail_at_done, n + 1);
      chk(done_cnt == 1, {tag, " R7 R8 single done strobe"}, done_cnt, 1);
      chk(busy_cnt == 2 * n * (exp_p + 1) + 3, {tag, " R7 R8 busy length"},
          busy_cnt, 2 * n * (exp_p + 1) + 3);
      chk(!busy_o && !scl_oe_o && !sda_oe_o, {tag, " R1 idle after run"},
          {busy_o, scl_oe_o, sda_oe_o}, 0);
   endtask

   // R9: count holds while idle
   task automatic t_hold(input int exp_p);
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(pulses_o == CNT_W'(exp_p), "R9 count holds while idle", pulses_o, exp_p);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
   end

   initial begin
      clear_rec();
      repeat (3) @(posedge clk);
      t_reset();
      #1 rst_n = 1'b1;
      t_reset();
      t_sda_free(4);
      t_recover(4, 3, 3, 1'b0, "release after 3");
      t_hold(3);
      t_recover(5, 1, 1, 1'b0, "release after 1");
      t_recover(3, 0, 9, 1'b0, "never released");
      t_hold(9);
      t_recover(4, 9, 9, 1'b0, "release at limit");
      t_recover(1, 0, 9, 1'b0, "one-cycle half");
      t_recover(6, 2, 2, 1'b1, "start while busy");
      t_sda_free(3);
      summary();
      $finish;
   end
endmodule